// File: doc/BRIEF.md
# Timer Bank Byte-Wide Host Register Interface

This block sits between an 8-bit host bus and a bank of three 16-bit timer channels. The two-bit address picks a channel data register (addresses 0, 1 and 2) or the shared command register (address 3). Command bytes set a channel's byte-access mode and its operating mode, or freeze its count for reading. Data writes build 16-bit reload values one byte at a time. Reads return the live or frozen count one byte at a time. The counting itself happens in the channels. This block only passes each channel a load strobe with its reload value and a mode-set strobe with its operating mode. It takes the live counts back in.

Each channel holds three small state machines. The write pointer has the states `PTR_LO` and `PTR_HI`. A data write moves it from `PTR_LO` to `PTR_HI` and back, but only in low-then-high access mode. A command with access mode 2 forces it to `PTR_HI`, and access modes 1 or 3 force it to `PTR_LO`. The read pointer has the same two states. It toggles on every read of its channel. The latch machine has the states `LAT_FREE` and `LAT_HELD`. A latch command moves it from `LAT_FREE` to `LAT_HELD`. Reading the high byte moves it back to `LAT_FREE`. Every strobe is registered, so it appears on the clock edge after the bus cycle that causes it and lasts one cycle.

Top module: `tmr_host_if`

## Requirements
- R1: After reset no strobe is active, every read pointer and write pointer is at the low byte, no channel is latched, and access mode and operating mode are 0. In access mode 0, a data write replaces the low byte and issues a load strobe.
- R2: A command byte is decoded as follows. Bits 7:6 give the channel, bits 5:4 the access mode (0 latch, 1 low only, 2 high only, 3 low then high), and bits 3:1 the operating mode. Bit 0 (BCD select) is not forwarded. A command with a non-zero access mode pulses `mode_stb_o` for that channel one cycle later, with `mode_o` holding bits 3:1.
- R3: A command with access mode 2 points the write pointer at the high byte. Access modes 1 and 3 point it at the low byte, whatever state it was in before.
- R4: In low-then-high mode, the first data write sets the low byte and issues no strobe. The second sets the high byte and pulses `load_stb_o` one cycle later, with the assembled value {high, low}. The pair then repeats.
- R5: In low-only or high-only mode, each data write replaces only that byte of the reload value, keeps the other byte, and pulses the load strobe one cycle later.
- R6: Reads of a channel return the low byte, then the high byte, alternating. The bytes come from the live count whenever no latch is held. `rdata` follows the address and the read pointer combinationally.
- R7: A latch command on a channel that is not latched captures its live count. Reads then return the captured value even when the live count changes.
- R8: While a latch is held, further latch commands to that channel are ignored. Reading the high byte releases the latch, and later reads return the live count.
- R9: A command with channel field 3 (read-back) changes nothing: no strobe, no change to any pointer, mode or latch.
- R10: A read of address 3 returns 0 and moves no read pointer.
- R11: A latch command leaves the channel's access mode, operating mode and write pointer unchanged and issues no mode-set strobe.
- R12: Each strobe lasts exactly one cycle, and at most one channel receives a load strobe in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write enable |
| rd_en | input | 1 | Bus read enable |
| addr | input | 2 | 0..2 channel data, 3 command |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte (combinational) |
| cnt_i | input | 3x16 | Live counts from the channels |
| load_stb_o | output | 3 | Per-channel reload strobe |
| load_val_o | output | 3x16 | Per-channel reload value |
| mode_stb_o | output | 3 | Per-channel mode-set strobe |
| mode_o | output | 3x3 | Per-channel operating mode |

## Verification
A write pointer in the wrong state shows on the very next data write. Either the load strobe arrives one write early or late, or the reload value has its bytes swapped. A read pointer in the wrong state shows at once as the wrong half of the count on `rdata`. A latch that is held or released at the wrong time shows as stale or moving count bytes on the next read of that channel. A read-back or latch command that wrongly disturbs state shows as an unexpected strobe, which the scoreboard flags in the cycle after the command.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 2 * BYTE_W;
    localparam int NUM_CH   = 3;
    localparam int ADDR_W   = 2;
    localparam int MODE_W   = 3;
    localparam int CMD_ADDR = NUM_CH;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_LOHI  = 2'd3
    } acc_mode_e;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } byte_ptr_e;

    typedef enum logic {
        LAT_FREE = 1'b0,
        LAT_HELD = 1'b1
    } latch_st_e;

    // Field order follows the command byte, MSB first.
    typedef struct packed {
        logic [1:0]        sel;
        acc_mode_e         acc;
        logic [MODE_W-1:0] op;
        logic              bcd;
    } cmd_word_t;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_host_pkg::*;
(
    input  logic                    cmd_we,
    input  logic [BYTE_W-1:0]       cmd_byte,
    output logic [NUM_CH-1:0]       latch_req,
    output logic [NUM_CH-1:0]       mode_req,
    output acc_mode_e               cmd_acc,
    output logic [MODE_W-1:0]       cmd_op
);
    cmd_word_t cw;
    assign cw      = cmd_word_t'(cmd_byte);
    assign cmd_acc = cw.acc;
    assign cmd_op  = cw.op;

    // Channel field 3 matches no channel, so a read-back command falls through (R9).
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        logic hit;
        assign hit          = cmd_we && (cw.sel == 2'(c));
        assign latch_req[c] = hit && (cw.acc == ACC_LATCH);
        assign mode_req[c]  = hit && (cw.acc != ACC_LATCH);
    end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_host_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                latch_req,
    input  logic                mode_req,
    input  acc_mode_e           cmd_acc,
    input  logic [MODE_W-1:0]   cmd_op,
    input  logic                wr_hit,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                rd_hit,
    input  logic [CNT_W-1:0]    cnt_i,
    output logic [BYTE_W-1:0]   rd_byte,
    output logic                load_stb_o,
    output logic [CNT_W-1:0]    load_val_o,
    output logic                mode_stb_o,
    output logic [MODE_W-1:0]   mode_o
);
    byte_ptr_e         wr_ptr_q, wr_ptr_d;
    byte_ptr_e         rd_ptr_q, rd_ptr_d;
    latch_st_e         lat_q, lat_d;
    acc_mode_e         acc_q;
    logic [MODE_W-1:0] op_q;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  latched_q;
    logic              load_stb_q, mode_stb_q;
    logic [CNT_W-1:0]  rd_src;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= PTR_LO;
            rd_ptr_q <= PTR_LO;
            lat_q    <= LAT_FREE;
        end else begin
            wr_ptr_q <= wr_ptr_d;
            rd_ptr_q <= rd_ptr_d;
            lat_q    <= lat_d;
        end
    end

    // Next-state logic
    always_comb begin
        wr_ptr_d = wr_ptr_q;
        if (mode_req) begin
            wr_ptr_d = (cmd_acc == ACC_HI) ? PTR_HI : PTR_LO;
        end else if (wr_hit && acc_q == ACC_LOHI) begin
            unique case (wr_ptr_q)
                PTR_LO: wr_ptr_d = PTR_HI;
                PTR_HI: wr_ptr_d = PTR_LO;
            endcase
        end
    end

    always_comb begin
        rd_ptr_d = rd_ptr_q;
        if (rd_hit) begin
            unique case (rd_ptr_q)
                PTR_LO: rd_ptr_d = PTR_HI;
                PTR_HI: rd_ptr_d = PTR_LO;
            endcase
        end
    end

    always_comb begin
        lat_d = lat_q;
        unique case (lat_q)
            LAT_FREE: if (latch_req) lat_d = LAT_HELD;
            LAT_HELD: if (rd_hit && rd_ptr_q == PTR_HI) lat_d = LAT_FREE;
        endcase
    end

    // Output / datapath process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= ACC_LATCH;
            op_q       <= '0;
            reload_q   <= '0;
            latched_q  <= '0;
            load_stb_q <= 1'b0;
            mode_stb_q <= 1'b0;
        end else begin
            load_stb_q <= 1'b0;
            mode_stb_q <= 1'b0;
            if (mode_req) begin
                acc_q      <= cmd_acc;
                op_q       <= cmd_op;
                mode_stb_q <= 1'b1;
            end
            if (latch_req && lat_q == LAT_FREE) begin
                latched_q <= cnt_i;
            end
            if (wr_hit) begin
                unique case (wr_ptr_q)
                    PTR_LO: begin
                        reload_q[BYTE_W-1:0] <= wdata;
                        load_stb_q           <= (acc_q != ACC_LOHI);
                    end
                    PTR_HI: begin
                        reload_q[CNT_W-1:BYTE_W] <= wdata;
                        load_stb_q               <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign rd_src     = (lat_q == LAT_HELD) ? latched_q : cnt_i;
    assign rd_byte    = (rd_ptr_q == PTR_LO) ? rd_src[BYTE_W-1:0] : rd_src[CNT_W-1:BYTE_W];
    assign load_stb_o = load_stb_q;
    assign load_val_o = reload_q;
    assign mode_stb_o = mode_stb_q;
    assign mode_o     = op_q;

    // R4: the low-byte write of a pair never loads
    p_pair_low_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && acc_q == ACC_LOHI && wr_ptr_q == PTR_LO) |=> !load_stb_o);

    // R6: every read of this channel moves its read pointer
    p_read_toggles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> (rd_ptr_q != $past(rd_ptr_q)));

    // R7: a held latch keeps its value until it is released
    p_latch_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q == LAT_HELD && !(rd_hit && rd_ptr_q == PTR_HI)) |=> $stable(latched_q));

    // R8: reading the high byte frees a held latch
    p_high_read_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q == LAT_HELD && rd_hit && rd_ptr_q == PTR_HI) |=> (lat_q == LAT_FREE));

    // R11: a latch command leaves the write pointer where it was
    p_latch_keeps_ptr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        latch_req |=> $stable(wr_ptr_q));

    // R12: the two strobes are single-cycle and never coincide
    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_stb_o && mode_stb_o));
    p_load_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb_o && !wr_hit) |=> !load_stb_o);
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
    import tmr_host_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             rd_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [BYTE_W-1:0]                wdata,
    output logic [BYTE_W-1:0]                rdata,
    input  logic [NUM_CH-1:0][CNT_W-1:0]     cnt_i,
    output logic [NUM_CH-1:0]                load_stb_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]     load_val_o,
    output logic [NUM_CH-1:0]                mode_stb_o,
    output logic [NUM_CH-1:0][MODE_W-1:0]    mode_o
);
    logic                           cmd_we;
    logic [NUM_CH-1:0]              latch_req, mode_req;
    acc_mode_e                      cmd_acc;
    logic [MODE_W-1:0]              cmd_op;
    logic [NUM_CH-1:0][BYTE_W-1:0]  rd_bytes;

    assign cmd_we = wr_en && (addr == ADDR_W'(CMD_ADDR));

    tmr_cmd_decode u_dec (
        .cmd_we    (cmd_we),
        .cmd_byte  (wdata),
        .latch_req (latch_req),
        .mode_req  (mode_req),
        .cmd_acc   (cmd_acc),
        .cmd_op    (cmd_op)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tmr_chan_port u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .latch_req  (latch_req[c]),
            .mode_req   (mode_req[c]),
            .cmd_acc    (cmd_acc),
            .cmd_op     (cmd_op),
            .wr_hit     (wr_en && addr == ADDR_W'(c)),
            .wdata      (wdata),
            .rd_hit     (rd_en && addr == ADDR_W'(c)),
            .cnt_i      (cnt_i[c]),
            .rd_byte    (rd_bytes[c]),
            .load_stb_o (load_stb_o[c]),
            .load_val_o (load_val_o[c]),
            .mode_stb_o (mode_stb_o[c]),
            .mode_o     (mode_o[c])
        );
    end

    // Address 3 and any unmatched address read as zero (R10)
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_W'(c)) rdata = rd_bytes[c];
        end
    end

    // R12: at most one channel loads in a cycle
    p_one_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb_o));

    // R9: a read-back command raises no strobe
    p_readback_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && wdata[7:6] == 2'b11) |=> (load_stb_o == '0 && mode_stb_o == '0));
endmodule

// File: tb/tmr_host_if_test.sv
module tmr_host_if_test;
    import tmr_host_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [BYTE_W-1:0] wdata = '0;
    logic [BYTE_W-1:0] rdata;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_i = '0;
    logic [NUM_CH-1:0]             load_stb_o, mode_stb_o;
    logic [NUM_CH-1:0][CNT_W-1:0]  load_val_o;
    logic [NUM_CH-1:0][MODE_W-1:0] mode_o;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        int          ch;
        bit          is_mode;
        logic [15:0] val;
        int          req;
    } exp_item_t;
    exp_item_t exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    tmr_host_if uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt_i(cnt_i), .load_stb_o(load_stb_o),
        .load_val_o(load_val_o), .mode_stb_o(mode_stb_o), .mode_o(mode_o)
    );

    task automatic check(bit ok, int req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL R%0d actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_load(int ch, logic [15:0] v, int req);
        exp_q.push_back('{ch: ch, is_mode: 1'b0, val: v, req: req});
    endtask

    task automatic push_mode(int ch, logic [2:0] m, int req);
        exp_q.push_back('{ch: ch, is_mode: 1'b1, val: {13'd0, m}, req: req});
    endtask

    // Monitor: every strobe must match the head of the expectation queue.
    task automatic observe(int ch, bit is_mode, logic [15:0] v);
        exp_item_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, 12, v, 16'hxxxx);   // unexpected strobe, R12/R9/R11
        end else begin
            e = exp_q.pop_front();
            check(e.ch == ch && e.is_mode == is_mode && e.val == v, e.req, v, e.val);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (load_stb_o[c]) observe(c, 1'b0, load_val_o[c]);
                if (mode_stb_o[c]) observe(c, 1'b1, {13'd0, mode_o[c]});
            end
        end
    end

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, logic [7:0] exp, int req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        check(rdata == exp, req, {8'd0, rdata}, {8'd0, exp});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, 0, 16'd0, 16'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        cnt_i[0] = 16'h1234; cnt_i[1] = 16'hABCD; cnt_i[2] = 16'h0F0E;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, no strobes, read pointer at low byte
        check(load_stb_o == '0 && mode_stb_o == '0, 1, {10'd0, load_stb_o, mode_stb_o}, 16'd0);
        addr = 2'd0; #1;
        check(rdata == 8'h34, 1, {8'd0, rdata}, 16'h0034);

        // R1: access mode 0 write goes to the low byte and loads
        push_load(0, 16'h005A, 1);
        bus_write(2'd0, 8'h5A);
        // R12: strobe lasts one cycle
        @(negedge clk);
        check(load_stb_o == '0, 12, {13'd0, load_stb_o}, 16'd0);

        // R2 R4: ch1 low-then-high, op 3
        push_mode(1, 3'd3, 2);
        bus_write(2'd3, 8'h76);
        bus_write(2'd1, 8'h34);
        push_load(1, 16'h1234, 4);
        bus_write(2'd1, 8'h12);
        bus_write(2'd1, 8'h78);
        push_load(1, 16'h5678, 4);
        bus_write(2'd1, 8'h56);

        // R3 R5: ch2 high only (bcd bit set, not forwarded), op 2
        push_mode(2, 3'd2, 3);
        bus_write(2'd3, 8'hA5);
        push_load(2, 16'h9C00, 5);
        bus_write(2'd2, 8'h9C);
        push_mode(2, 3'd0, 2);
        bus_write(2'd3, 8'h90);
        push_load(2, 16'h9C11, 5);
        bus_write(2'd2, 8'h11);
        push_load(2, 16'h9C22, 5);
        bus_write(2'd2, 8'h22);

        // R3: re-issuing a low-then-high command rewinds the write pointer
        push_mode(1, 3'd3, 3);
        bus_write(2'd3, 8'h76);
        bus_write(2'd1, 8'hAA);
        push_mode(1, 3'd3, 3);
        bus_write(2'd3, 8'h76);
        bus_write(2'd1, 8'hBB);
        push_load(1, 16'hCCBB, 3);
        bus_write(2'd1, 8'hCC);

        // R6: alternating live reads
        bus_read(2'd1, 8'hCD, 6);
        bus_read(2'd1, 8'hAB, 6);
        bus_read(2'd1, 8'hCD, 6);

        // R7 R11: latch command (op bits set, ignored), then live count moves
        bus_write(2'd3, 8'h0E);
        cnt_i[0] = 16'h7777;
        bus_read(2'd0, 8'h34, 7);
        // R8: second latch ignored while held
        cnt_i[0] = 16'h8899;
        bus_write(2'd3, 8'h00);
        bus_read(2'd0, 8'h12, 8);
        // R8: released, live again
        bus_read(2'd0, 8'h99, 8);
        bus_read(2'd0, 8'h88, 8);
        // R11: access mode still 0 -> low byte replaced and loaded
        push_load(0, 16'h0044, 11);
        bus_write(2'd0, 8'h44);

        // R9: read-back commands do nothing
        bus_write(2'd3, 8'hC2);
        bus_write(2'd3, 8'hFE);
        cnt_i[0] = 16'h4321;
        bus_read(2'd0, 8'h21, 9);
        bus_read(2'd0, 8'h43, 9);
        bus_write(2'd1, 8'h01);
        push_load(1, 16'h0201, 9);
        bus_write(2'd1, 8'h02);

        // R10: address 3 reads zero and moves no pointer
        bus_read(2'd3, 8'h00, 10);
        bus_read(2'd2, 8'h0E, 10);
        bus_read(2'd3, 8'h00, 10);
        bus_read(2'd2, 8'h0F, 10);

        repeat (3) @(negedge clk);
        // R12: every expected strobe seen, none left over
        check(exp_q.size() == 0, 12, 16'(exp_q.size()), 16'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule